// File: doc/BRIEF.md
# Machine-Mode Trap Entry and Return Unit

This block owns the machine-level trap state of a small hart that runs in machine (M) and user (U) privilege only. The pipeline hands it a trap request, tagged as an interrupt or an exception, with a cause code and a program counter. It also hands it a return-from-trap request. In the same cycle the block answers with a redirect target. On the following clock edge it updates the saved PC, the cause register, the privilege and the interrupt-enable stack.

The trap vector, saved PC, cause and status registers are reachable through a single-cycle CSR port. The port has a two-bit register select: 0 is the trap vector, 1 is the saved PC, 2 is the cause and 3 is the status. A write takes effect at the clock edge. The read data is combinational from the current state. When a trap, a return and a CSR write land in the same cycle, the priority is trap first, then return, then the CSR write.

Top module: `mtrap_unit`

## Requirements
- R1: After reset the hart is in M-mode. The trap vector, saved PC, cause and status all read as zero, and no redirect is signalled.
- R2: A trap saves its PC into the saved-PC register with bit 0 cleared. It also loads the cause register with bit XLEN-1 set for an interrupt and clear for an exception, and the cause code in the low bits. The supported codes include 2, 7, 8 and 12.
- R3: On trap entry the previous-enable bit (status bit 7) takes the old enable bit (status bit 3). The enable bit is cleared. The previous-privilege field (status bits 12:11, 00 = U, 11 = M) takes the current privilege. The hart enters M-mode.
- R4: With the vector mode field (trap vector bits 1:0) at 0, every trap redirects to the base, which is the trap vector with bits 1:0 cleared.
- R5: With mode field 1, an exception redirects to the base and an interrupt redirects to the base plus four times its cause code.
- R6: A return redirects to the saved PC. It restores the privilege from the previous-privilege field and copies the previous-enable bit into the enable bit. It then sets the previous-enable bit to 1 and the previous-privilege field to U.
- R7: When a trap and a return are requested in the same cycle, only the trap takes effect, both for the redirect target and for the state update.
- R8: A write of mode 2 or 3 to the trap vector is stored as mode 0. It reads back as 0 and redirects as direct mode.
- R9: Bit 0 of the saved PC always reads as zero, including after a CSR write of an odd value.
- R10: CSR writes load the selected register on the next edge. A status write of previous privilege 01 or 10 is stored as U. A trap in the same cycle overrides writes to the saved PC, cause and status, and a return overrides a status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Trap request this cycle |
| trap_irq | input | 1 | 1 = interrupt, 0 = synchronous exception |
| trap_code | input | CODE_W | Cause code of the trap |
| trap_pc | input | XLEN | Faulting or interrupted PC |
| mret_req | input | 1 | Return-from-trap request this cycle |
| csr_we | input | 1 | CSR write enable |
| csr_sel | input | 2 | Register select: 0 vector, 1 saved PC, 2 cause, 3 status |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data for the selected register |
| redirect_valid | output | 1 | Fetch must be redirected this cycle |
| redirect_pc | output | XLEN | Redirect target |
| priv_m | output | 1 | 1 when the hart is in M-mode, 0 in U-mode |
| irq_enable | output | 1 | Current machine interrupt-enable bit |

## Verification
A trap and a return can be requested in the same cycle. The bench provokes this in a directed case and in many random cycles, where both requests are drawn independently. In each such cycle it checks that the redirect equals the trap target and not the saved PC. It also checks that the following state reads show the trap-entry stacking and no return unstacking. The same random cycles mix in CSR writes, so that write-versus-trap and write-versus-return collisions are judged against the bench model through the read port.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;
   typedef enum logic [1:0] {
      SEL_TVEC   = 2'd0,
      SEL_EPC    = 2'd1,
      SEL_CAUSE  = 2'd2,
      SEL_STATUS = 2'd3
   } csr_sel_e;

   localparam logic [1:0] PRIV_U = 2'b00;
   localparam logic [1:0] PRIV_M = 2'b11;

   localparam int ST_IE     = 3;
   localparam int ST_PIE    = 7;
   localparam int ST_PP_LO  = 11;
   localparam int ST_PP_HI  = 12;
endpackage

// File: rtl/mtrap_target.sv
module mtrap_target #(
   parameter int XLEN   = 32,
   parameter int CODE_W = 6,
   parameter bit VEC_EN = 1'b1
) (
   input  logic [XLEN-3:0]   tvec_base,
   input  logic              tvec_vec,
   input  logic              is_irq,
   input  logic [CODE_W-1:0] code,
   output logic [XLEN-1:0]   target
);
   localparam int PAD_W = XLEN - CODE_W - 2;

   logic [XLEN-1:0] base_addr;
   assign base_addr = {tvec_base, 2'b00};

   if (VEC_EN) begin : g_vectored
      logic [XLEN-1:0] offset;
      assign offset = {{PAD_W{1'b0}}, code, 2'b00};
      assign target = (tvec_vec && is_irq) ? base_addr + offset : base_addr;
   end else begin : g_direct
      logic unused_vec_in;
      assign unused_vec_in = tvec_vec ^ is_irq ^ (^code);
      assign target = base_addr;
   end
endmodule

// File: rtl/mtrap_status.sv
module mtrap_status
   import mtrap_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       take_trap,
   input  logic       take_mret,
   input  logic       we_status,
   input  logic       w_ie,
   input  logic       w_pie,
   input  logic [1:0] w_pp,
   output logic [1:0] priv,
   output logic       ie,
   output logic       pie,
   output logic [1:0] pp
);
   logic [1:0] pp_legal;
   assign pp_legal = (w_pp == PRIV_M) ? PRIV_M : PRIV_U;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         priv <= PRIV_M;
         ie   <= 1'b0;
         pie  <= 1'b0;
         pp   <= PRIV_U;
      end else if (take_trap) begin
         pie  <= ie;
         ie   <= 1'b0;
         pp   <= priv;
         priv <= PRIV_M;
      end else if (take_mret) begin
         priv <= pp;
         ie   <= pie;
         pie  <= 1'b1;
         pp   <= PRIV_U;
      end else if (we_status) begin
         ie   <= w_ie;
         pie  <= w_pie;
         pp   <= pp_legal;
      end
   end

   p_trap_enter_m_r3: assert property (@(posedge clk) disable iff (!rst_n)
      take_trap |=> (priv == PRIV_M) && !ie && (pie == $past(ie)) && (pp == $past(priv)));

   p_mret_unstack_r6: assert property (@(posedge clk) disable iff (!rst_n)
      take_mret |=> (ie == $past(pie)) && pie && (pp == PRIV_U) && (priv == $past(pp)));

   p_pp_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pp == PRIV_U) || (pp == PRIV_M));
endmodule

// File: rtl/mtrap_csrs.sv
module mtrap_csrs #(
   parameter int              XLEN       = 32,
   parameter int              CODE_W     = 6,
   parameter bit              HAS_C      = 1'b1,
   parameter bit              VEC_EN     = 1'b1,
   parameter logic [XLEN-1:0] RESET_TVEC = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_trap,
   input  logic              trap_irq,
   input  logic [CODE_W-1:0] trap_code,
   input  logic [XLEN-1:0]   trap_pc,
   input  logic              we_tvec,
   input  logic              we_epc,
   input  logic              we_cause,
   input  logic [XLEN-1:0]   wdata,
   output logic [XLEN-3:0]   tvec_base,
   output logic              tvec_vec,
   output logic [XLEN-1:0]   epc,
   output logic              cause_irq,
   output logic [CODE_W-1:0] cause_code
);
   localparam int EPC_LSB = HAS_C ? 1 : 2;

   logic [XLEN-1:EPC_LSB] epc_q;
   logic                  vec_wr;
   logic                  vec_rst;
   logic                  unused_pc_lo;

   assign unused_pc_lo = ^trap_pc[EPC_LSB-1:0];

   if (VEC_EN) begin : g_mode_vec
      assign vec_wr  = (wdata[1:0] == 2'b01);
      assign vec_rst = (RESET_TVEC[1:0] == 2'b01);
   end else begin : g_mode_dir
      assign vec_wr  = 1'b0;
      assign vec_rst = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tvec_base <= RESET_TVEC[XLEN-1:2];
         tvec_vec  <= vec_rst;
      end else if (we_tvec) begin
         tvec_base <= wdata[XLEN-1:2];
         tvec_vec  <= vec_wr;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         epc_q      <= '0;
         cause_irq  <= 1'b0;
         cause_code <= '0;
      end else if (take_trap) begin
         epc_q      <= trap_pc[XLEN-1:EPC_LSB];
         cause_irq  <= trap_irq;
         cause_code <= trap_code;
      end else begin
         if (we_epc)   epc_q <= wdata[XLEN-1:EPC_LSB];
         if (we_cause) begin
            cause_irq  <= wdata[XLEN-1];
            cause_code <= wdata[CODE_W-1:0];
         end
      end
   end

   assign epc = {epc_q, {EPC_LSB{1'b0}}};

   p_epc_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      take_trap |=> (epc[XLEN-1:EPC_LSB] == $past(trap_pc[XLEN-1:EPC_LSB]))
                    && (cause_irq == $past(trap_irq)) && (cause_code == $past(trap_code)));

   p_epc_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
      epc[0] == 1'b0);
endmodule

// File: rtl/mtrap_unit.sv
module mtrap_unit
   import mtrap_pkg::*;
#(
   parameter int              XLEN       = 32,
   parameter int              CODE_W     = 6,
   parameter bit              HAS_C      = 1'b1,
   parameter bit              VEC_EN     = 1'b1,
   parameter logic [XLEN-1:0] RESET_TVEC = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trap_req,
   input  logic              trap_irq,
   input  logic [CODE_W-1:0] trap_code,
   input  logic [XLEN-1:0]   trap_pc,
   input  logic              mret_req,
   input  logic              csr_we,
   input  logic [1:0]        csr_sel,
   input  logic [XLEN-1:0]   csr_wdata,
   output logic [XLEN-1:0]   csr_rdata,
   output logic              redirect_valid,
   output logic [XLEN-1:0]   redirect_pc,
   output logic              priv_m,
   output logic              irq_enable
);
   localparam int CAUSE_PAD = XLEN - 1 - CODE_W;

   if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
      $error("mtrap_unit: XLEN must be 32 or 64");
   end
   if (CODE_W < 4 || CODE_W > XLEN - 8) begin : g_bad_code
      $error("mtrap_unit: CODE_W out of range");
   end

   csr_sel_e sel;
   assign sel = csr_sel_e'(csr_sel);

   logic take_trap, take_mret;
   assign take_trap = trap_req;
   assign take_mret = mret_req && !trap_req;

   logic we_tvec, we_epc, we_cause, we_status;
   assign we_tvec   = csr_we && (sel == SEL_TVEC);
   assign we_epc    = csr_we && (sel == SEL_EPC);
   assign we_cause  = csr_we && (sel == SEL_CAUSE);
   assign we_status = csr_we && (sel == SEL_STATUS);

   logic [XLEN-3:0]   tvec_base;
   logic              tvec_vec;
   logic [XLEN-1:0]   epc;
   logic              cause_irq;
   logic [CODE_W-1:0] cause_code;
   logic [1:0]        priv, pp;
   logic              ie, pie;
   logic [XLEN-1:0]   trap_target;

   mtrap_csrs #(
      .XLEN(XLEN), .CODE_W(CODE_W), .HAS_C(HAS_C),
      .VEC_EN(VEC_EN), .RESET_TVEC(RESET_TVEC)
   ) u_csrs (
      .clk(clk), .rst_n(rst_n),
      .take_trap(take_trap), .trap_irq(trap_irq),
      .trap_code(trap_code), .trap_pc(trap_pc),
      .we_tvec(we_tvec), .we_epc(we_epc), .we_cause(we_cause),
      .wdata(csr_wdata),
      .tvec_base(tvec_base), .tvec_vec(tvec_vec), .epc(epc),
      .cause_irq(cause_irq), .cause_code(cause_code)
   );

   mtrap_status u_status (
      .clk(clk), .rst_n(rst_n),
      .take_trap(take_trap), .take_mret(take_mret),
      .we_status(we_status),
      .w_ie(csr_wdata[ST_IE]), .w_pie(csr_wdata[ST_PIE]),
      .w_pp(csr_wdata[ST_PP_HI:ST_PP_LO]),
      .priv(priv), .ie(ie), .pie(pie), .pp(pp)
   );

   mtrap_target #(
      .XLEN(XLEN), .CODE_W(CODE_W), .VEC_EN(VEC_EN)
   ) u_target (
      .tvec_base(tvec_base), .tvec_vec(tvec_vec),
      .is_irq(trap_irq), .code(trap_code), .target(trap_target)
   );

   assign redirect_valid = take_trap || take_mret;
   assign redirect_pc    = take_trap ? trap_target : epc;
   assign priv_m         = (priv == PRIV_M);
   assign irq_enable     = ie;

   always_comb begin
      csr_rdata = '0;
      unique case (sel)
         SEL_TVEC:   csr_rdata = {tvec_base, 1'b0, tvec_vec};
         SEL_EPC:    csr_rdata = epc;
         SEL_CAUSE:  csr_rdata = {cause_irq, {CAUSE_PAD{1'b0}}, cause_code};
         SEL_STATUS: begin
            csr_rdata[ST_IE]            = ie;
            csr_rdata[ST_PIE]           = pie;
            csr_rdata[ST_PP_HI:ST_PP_LO] = pp;
         end
      endcase
   end

   p_exc_to_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_req && !trap_irq) |-> (redirect_pc == {tvec_base, 2'b00}));

   p_trap_beats_mret_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_req && mret_req) |=> priv_m && !irq_enable);

   p_mode_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_we && (csr_sel == 2'd0) && csr_wdata[1]) |=> !tvec_vec);
endmodule

// File: tb/mtrap_unit_tb.sv
`timescale 1ns/1ps
module mtrap_unit_tb;
   localparam int XLEN = 32;
   localparam int CODE_W = 6;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              trap_req, trap_irq, mret_req, csr_we;
   logic [CODE_W-1:0] trap_code;
   logic [XLEN-1:0]   trap_pc, csr_wdata, csr_rdata, redirect_pc;
   logic [1:0]        csr_sel;
   logic              redirect_valid, priv_m, irq_enable;

   always #10 clk = ~clk;

   mtrap_unit u_dut (
      .clk(clk), .rst_n(rst_n),
      .trap_req(trap_req), .trap_irq(trap_irq), .trap_code(trap_code), .trap_pc(trap_pc),
      .mret_req(mret_req), .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
      .csr_rdata(csr_rdata), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
      .priv_m(priv_m), .irq_enable(irq_enable)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   logic [XLEN-3:0]   m_base;
   logic              m_vec;
   logic [XLEN-1:0]   m_epc;
   logic              m_cirq;
   logic [CODE_W-1:0] m_ccode;
   logic [1:0]        m_priv, m_pp;
   logic              m_ie, m_pie;

   task automatic chk(string tag, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   function automatic logic [XLEN-1:0] exp_target(logic irq, logic [CODE_W-1:0] code);
      logic [XLEN-1:0] b = {m_base, 2'b00};
      if (m_vec && irq) return b + {{(XLEN-CODE_W-2){1'b0}}, code, 2'b00};
      return b;
   endfunction

   function automatic logic [XLEN-1:0] exp_rdata(logic [1:0] sel);
      logic [XLEN-1:0] r = '0;
      case (sel)
         2'd0: r = {m_base, 1'b0, m_vec};
         2'd1: r = m_epc;
         2'd2: r = {m_cirq, {(XLEN-1-CODE_W){1'b0}}, m_ccode};
         default: begin r[3] = m_ie; r[7] = m_pie; r[12:11] = m_pp; end
      endcase
      return r;
   endfunction

   task automatic model_reset();
      m_base = '0; m_vec = 1'b0; m_epc = '0; m_cirq = 1'b0; m_ccode = '0;
      m_priv = 2'b11; m_pp = 2'b00; m_ie = 1'b0; m_pie = 1'b0;
   endtask

   task automatic step(string rtag, logic t, logic irq, logic [CODE_W-1:0] code,
                       logic [XLEN-1:0] pc, logic mr, logic we, logic [1:0] sel,
                       logic [XLEN-1:0] wd);
      @(negedge clk);
      trap_req = t; trap_irq = irq; trap_code = code; trap_pc = pc;
      mret_req = mr; csr_we = we; csr_sel = sel; csr_wdata = wd;
      #1;
      chk(rtag, csr_rdata, exp_rdata(sel));
      chk("R6 redirect_valid", {31'd0, redirect_valid}, {31'd0, t | mr});
      chk("R3 priv_m", {31'd0, priv_m}, {31'd0, m_priv == 2'b11});
      chk("R3 irq_enable", {31'd0, irq_enable}, {31'd0, m_ie});
      if (t)
         chk(mr ? "R7 trap over mret target" : (m_vec ? "R5 vectored target" : "R4 direct target"),
             redirect_pc, exp_target(irq, code));
      else if (mr)
         chk("R6 mret target", redirect_pc, m_epc);
      @(posedge clk);
      if (t) begin
         m_epc = {pc[XLEN-1:1], 1'b0}; m_cirq = irq; m_ccode = code;
         m_pie = m_ie; m_ie = 1'b0; m_pp = m_priv; m_priv = 2'b11;
      end else if (mr) begin
         m_priv = m_pp; m_ie = m_pie; m_pie = 1'b1; m_pp = 2'b00;
      end
      if (we) begin
         if (sel == 2'd0) begin m_base = wd[XLEN-1:2]; m_vec = (wd[1:0] == 2'b01); end
         if (sel == 2'd1 && !t) m_epc = {wd[XLEN-1:1], 1'b0};
         if (sel == 2'd2 && !t) begin m_cirq = wd[XLEN-1]; m_ccode = wd[CODE_W-1:0]; end
         if (sel == 2'd3 && !t && !mr) begin
            m_ie = wd[3]; m_pie = wd[7]; m_pp = (wd[12:11] == 2'b11) ? 2'b11 : 2'b00;
         end
      end
   endtask

   task automatic idle_read(string tag, logic [1:0] sel);
      step(tag, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, sel, '0);
   endtask

   task automatic wr(string tag, logic [1:0] sel, logic [XLEN-1:0] wd);
      step(tag, 1'b0, 1'b0, '0, '0, 1'b0, 1'b1, sel, wd);
   endtask

   initial begin
      #(20 * 200000);
      if (!finished) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0;
      trap_req = 0; trap_irq = 0; trap_code = '0; trap_pc = '0;
      mret_req = 0; csr_we = 0; csr_sel = '0; csr_wdata = '0;
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values on every register, M-mode, no redirect
      idle_read("R1 reset tvec", 2'd0);
      idle_read("R1 reset epc", 2'd1);
      idle_read("R1 reset cause", 2'd2);
      idle_read("R1 reset status", 2'd3);

      // R6: return from reset state goes to U with pie set
      step("R6 status pre", 1'b0, 1'b0, '0, '0, 1'b1, 1'b0, 2'd3, '0);
      idle_read("R6 status after mret", 2'd3);

      // R8: mode 2 stored as direct
      wr("R8 tvec write", 2'd0, 32'h0000_0102);
      idle_read("R8 tvec readback", 2'd0);
      // R4: interrupt in direct mode goes to base; trap from U
      step("R4 irq direct", 1'b1, 1'b1, 6'd7, 32'h0000_0800, 1'b0, 1'b0, 2'd0, '0);
      idle_read("R3 status after trap from U", 2'd3);
      idle_read("R2 epc after irq", 2'd1);
      idle_read("R2 cause after irq", 2'd2);

      // R5: vectored mode, ecall (8) goes to base, timer (7) to base+28
      wr("R5 tvec vectored", 2'd0, 32'h0000_0201);
      wr("R10 status ie", 2'd3, 32'h0000_0008);
      step("R5 ecall", 1'b1, 1'b0, 6'd8, 32'h0000_1234, 1'b0, 1'b0, 2'd3, '0);
      idle_read("R3 status stacked", 2'd3);
      idle_read("R2 epc ecall", 2'd1);
      idle_read("R2 cause ecall", 2'd2);
      step("R5 timer irq", 1'b1, 1'b1, 6'd7, 32'h0000_4002, 1'b0, 1'b0, 2'd0, '0);
      idle_read("R2 cause timer", 2'd2);

      // R9: odd saved PC reads even
      wr("R9 epc write", 2'd1, 32'h0000_0003);
      idle_read("R9 epc readback", 2'd1);

      // R10: illegal previous-privilege stored as U
      wr("R10 status write", 2'd3, 32'h0000_1088);
      idle_read("R10 status readback", 2'd3);

      // R7: trap and mret together, illegal instruction (2)
      step("R7 collide", 1'b1, 1'b0, 6'd2, 32'h0000_0100, 1'b1, 1'b0, 2'd3, '0);
      idle_read("R7 status after collide", 2'd3);
      // R10: trap overrides saved-PC write, page fault (12)
      step("R10 trap vs write", 1'b1, 1'b0, 6'd12, 32'h0000_0a00, 1'b0, 1'b1, 2'd1, 32'h0000_5550);
      idle_read("R10 epc kept trap pc", 2'd1);
      idle_read("R2 cause page fault", 2'd2);

      for (int i = 0; i < 4000; i++) begin
         logic t, mr, we, irq;
         logic [1:0] sel;
         logic [XLEN-1:0] wd;
         t   = ($urandom % 4) == 0;
         mr  = ($urandom % 4) == 0;
         we  = ($urandom % 2) == 0;
         irq = $urandom % 2;
         sel = $urandom % 4;
         wd  = $urandom;
         if (sel == 2'd0 && ($urandom % 2)) wd[1:0] = 2'b01;
         step("R10 random read", t, irq, CODE_W'($urandom), $urandom, mr, we, sel, wd);
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule